// File: doc/BRIEF.md
# Status Register Write Guard

This block keeps the one-byte status register of a serial nonvolatile memory and rules on every request that would change the memory or that register. The command decoder drives it with single-cycle request strobes: set or clear the write-enable latch, write the status byte, program a page, erase one sector, erase the whole array, and a completion strobe when the array sequencer finishes a cycle. The guard answers in the same cycle with an accept strobe for each request kind. The decoder starts the cycle only when it sees that strobe.

The register holds a lock bit, three area-select bits, the write-enable latch and a live busy flag. The area-select code marks a protected range of sectors that starts at the highest sector and grows downward. A separate rule allows a whole-array erase only when no range is protected. When the lock bit is set and the write-protect pin is held low, the status byte becomes read-only. The nonvolatile fields are modelled as ordinary flops that clear on reset.

The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `sreg_guard`

## Requirements
- R1: After reset the status byte reads 00h.
- R2: The status byte layout is: bit 7 lock, bits 6 and 5 always 0, bits 4..2 area code (bit 4 most significant), bit 1 write-enable latch, bit 0 a live copy of the `busy` input.
- R3: `wen_set` sets the latch and `wen_clr` clears it from the next cycle. If both are strobed together, clear wins. Both are ignored while `busy` is 1.
- R4: `cycle_done` clears the latch in the next cycle, whatever else is requested in that cycle.
- R5: An accepted status write loads only bits 7 and 4..2 from `swr_data`, from the next cycle. Bits 6, 5, 1 and 0 of `swr_data` have no effect. Without an accepted write, bits 7 and 4..2 hold.
- R6: A status write is refused whenever the lock bit is 1 and `wp_n` is 0, whichever of the two came first. `hw_locked` reports this condition.
- R7: No program, sector erase, full erase or status write is accepted while the latch is 0.
- R8: Program and sector-erase requests are refused for a protected sector. Area code 000 protects none, 001 protects sector 7, 010 protects sectors 6 and 7, 011 protects sectors 4 to 7, and any code with bit 2 set protects all eight.
- R9: A full erase is accepted only when the area code is 000.
- R10: While `busy` is 1, every request is refused.
- R11: A refused request leaves the latch and the status byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wp_n | input | 1 | Write-protect pin, low asserts |
| busy | input | 1 | Array or register cycle running |
| wen_set | input | 1 | Strobe: set write-enable latch |
| wen_clr | input | 1 | Strobe: clear write-enable latch |
| swr_req | input | 1 | Strobe: status write request |
| swr_data | input | 8 | Byte offered by the status write |
| prog_req | input | 1 | Strobe: page program request |
| serase_req | input | 1 | Strobe: sector erase request |
| berase_req | input | 1 | Strobe: full erase request |
| sector | input | SECT_W | Target sector of program or sector erase |
| cycle_done | input | 1 | Strobe: running cycle finished |
| status_q | output | 8 | Status byte for reads |
| prog_ok | output | 1 | Program request accepted |
| serase_ok | output | 1 | Sector erase accepted |
| berase_ok | output | 1 | Full erase accepted |
| swr_ok | output | 1 | Status write accepted |
| hw_locked | output | 1 | Lock bit set and pin low |

## Verification
The assertions assume the decoder raises at most one strobe per cycle, except for the deliberate set-and-clear collision. They also assume `cycle_done` arrives only after an accepted request. The bench drives one strobe per call from a task, with an idle cycle between calls. It raises the completion strobe only after a write it has seen accepted, and it holds `busy` low except in the phase that tests R10. Area-code decoding is swept over all 64 code and sector pairs, and the status write over all 256 data bytes.

// File: rtl/sreg_guard_pkg.sv
package sreg_guard_pkg;

  localparam int SECT_W_DEF = 3;
  localparam int AREA_W     = 3;

  // Byte view of the status register, bit 7 first.
  typedef struct packed {
    logic              lock;
    logic [1:0]        rsvd;
    logic [AREA_W-1:0] area;
    logic              wel;
    logic              wip;
  } sreg_view_t;

  localparam sreg_view_t SREG_RESET = '0;

endpackage

// File: rtl/sreg_guard_area.sv
module sreg_guard_area
  import sreg_guard_pkg::*;
#(
  parameter int SECT_W = SECT_W_DEF
) (
  input  logic [AREA_W-1:0] area,
  input  logic [SECT_W-1:0] sector,
  output logic              sect_locked,
  output logic              all_clear
);

  localparam int NUM_SECT = 1 << SECT_W;
  localparam int LOW_W    = AREA_W - 1;

  logic [LOW_W-1:0]    low_code;
  logic                all_code;
  int                  span;
  logic [NUM_SECT-1:0] lock_vec;

  assign low_code = area[LOW_W-1:0];
  assign all_code = area[AREA_W-1];

  // Number of sectors protected from the top, from the low code bits.
  always_comb begin
    if (low_code == '0) span = 0;
    else                span = 1 << (int'(low_code) - 1);
  end

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    assign lock_vec[s] = all_code | ((span != 0) && (s >= NUM_SECT - span));
  end

  assign sect_locked = lock_vec[sector];
  assign all_clear   = (area == '0);

endmodule

// File: rtl/sreg_guard_latch.sv
module sreg_guard_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic set_req,
  input  logic clr_req,
  input  logic done,
  output logic wel
);

  logic wel_d;
  logic wel_en;

  always_comb begin
    wel_en = 1'b0;
    wel_d  = wel;
    if (done) begin
      wel_en = 1'b1;
      wel_d  = 1'b0;
    end else if (!busy && clr_req) begin
      wel_en = 1'b1;
      wel_d  = 1'b0;
    end else if (!busy && set_req) begin
      wel_en = 1'b1;
      wel_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wel <= 1'b0;
    else if (wel_en) wel <= wel_d;
  end

endmodule

// File: rtl/sreg_guard_nvbits.sv
module sreg_guard_nvbits
  import sreg_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              lock_in,
  input  logic [AREA_W-1:0] area_in,
  output logic              lock,
  output logic [AREA_W-1:0] area
);

  logic              lock_d;
  logic [AREA_W-1:0] area_d;

  always_comb begin
    lock_d = lock;
    area_d = area;
    if (load) begin
      lock_d = lock_in;
      area_d = area_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0;
      area <= '0;
    end else if (load) begin
      lock <= lock_d;
      area <= area_d;
    end
  end

endmodule

// File: rtl/sreg_guard.sv
module sreg_guard
  import sreg_guard_pkg::*;
#(
  parameter int SECT_W = SECT_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_n,
  input  logic              busy,
  input  logic              wen_set,
  input  logic              wen_clr,
  input  logic              swr_req,
  input  logic [7:0]        swr_data,
  input  logic              prog_req,
  input  logic              serase_req,
  input  logic              berase_req,
  input  logic [SECT_W-1:0] sector,
  input  logic              cycle_done,
  output logic [7:0]        status_q,
  output logic              prog_ok,
  output logic              serase_ok,
  output logic              berase_ok,
  output logic              swr_ok,
  output logic              hw_locked
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              wel;
  logic              lock;
  logic [AREA_W-1:0] area;
  logic              sect_locked;
  logic              all_clear;
  logic              gate_open;
  sreg_view_t        wr_view;
  sreg_view_t        rd_view;
  logic              unused_wr_bits;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign wr_view        = sreg_view_t'(swr_data);
  assign unused_wr_bits = ^{wr_view.rsvd, wr_view.wel, wr_view.wip};

  sreg_guard_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .busy    (busy),
    .set_req (wen_set),
    .clr_req (wen_clr),
    .done    (cycle_done),
    .wel     (wel)
  );

  sreg_guard_nvbits u_nv (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (swr_ok),
    .lock_in (wr_view.lock),
    .area_in (wr_view.area),
    .lock    (lock),
    .area    (area)
  );

  sreg_guard_area #(.SECT_W(SECT_W)) u_area (
    .area        (area),
    .sector      (sector),
    .sect_locked (sect_locked),
    .all_clear   (all_clear)
  );

  // Rulings on requests.
  assign gate_open = wel & ~busy;
  assign hw_locked = lock & ~wp_n;
  assign swr_ok    = swr_req    & gate_open & ~hw_locked;
  assign prog_ok   = prog_req   & gate_open & ~sect_locked;
  assign serase_ok = serase_req & gate_open & ~sect_locked;
  assign berase_ok = berase_req & gate_open & all_clear;

  // Read view.
  always_comb begin
    rd_view      = SREG_RESET;
    rd_view.lock = lock;
    rd_view.area = area;
    rd_view.wel  = wel;
    rd_view.wip  = busy;
  end
  assign status_q = rd_view;

endmodule

// File: rtl/sreg_guard_chk.sv
module sreg_guard_chk #(
  parameter int SECT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_n,
  input logic              busy,
  input logic              wen_set,
  input logic              wen_clr,
  input logic              cycle_done,
  input logic [SECT_W-1:0] sector,
  input logic [7:0]        status_q,
  input logic              prog_ok,
  input logic              serase_ok,
  input logic              berase_ok,
  input logic              swr_ok
);

  logic any_ok;
  assign any_ok = prog_ok | serase_ok | berase_ok | swr_ok;

  assert_wel_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wen_set && !wen_clr && !busy && !cycle_done) |=> status_q[1]);

  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_done |=> !status_q[1]);

  assert_fields_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !swr_ok |=> $stable({status_q[7], status_q[4:2]}));

  assert_lock_refuses_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swr_ok |-> !(status_q[7] && !wp_n));

  assert_need_wel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any_ok |-> status_q[1]);

  assert_top_sector_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_ok || serase_ok) && (sector == {SECT_W{1'b1}})) |-> (status_q[4:2] == 3'b000));

  assert_full_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    berase_ok |-> (status_q[4:2] == 3'b000));

  assert_busy_refuses_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !any_ok);

endmodule

bind sreg_guard sreg_guard_chk #(.SECT_W(SECT_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .wp_n       (wp_n),
  .busy       (busy),
  .wen_set    (wen_set),
  .wen_clr    (wen_clr),
  .cycle_done (cycle_done),
  .sector     (sector),
  .status_q   (status_q),
  .prog_ok    (prog_ok),
  .serase_ok  (serase_ok),
  .berase_ok  (berase_ok),
  .swr_ok     (swr_ok)
);

// File: tb/sreg_guard_tb.sv
`timescale 1ns/1ps
module sreg_guard_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wp_n, busy, wen_set, wen_clr, swr_req, prog_req, serase_req, berase_req, cycle_done;
  logic [7:0] swr_data;
  logic [2:0] sector;
  logic [7:0] status_q;
  logic       prog_ok, serase_ok, berase_ok, swr_ok, hw_locked;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  sreg_guard dut_i (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .busy(busy),
    .wen_set(wen_set), .wen_clr(wen_clr), .swr_req(swr_req), .swr_data(swr_data),
    .prog_req(prog_req), .serase_req(serase_req), .berase_req(berase_req),
    .sector(sector), .cycle_done(cycle_done), .status_q(status_q),
    .prog_ok(prog_ok), .serase_ok(serase_ok), .berase_ok(berase_ok),
    .swr_ok(swr_ok), .hw_locked(hw_locked)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic idle_all();
    wen_set = 0; wen_clr = 0; swr_req = 0; prog_req = 0;
    serase_req = 0; berase_req = 0; cycle_done = 0;
  endtask

  // kind: 0 set, 1 clear, 2 status write, 3 program, 4 sector erase, 5 full erase, 6 done
  task automatic strobe(input int kind, input logic [7:0] d, input logic [2:0] s, output logic ok);
    @(negedge clk);
    swr_data = d;
    sector   = s;
    case (kind)
      0: wen_set    = 1;
      1: wen_clr    = 1;
      2: swr_req    = 1;
      3: prog_req   = 1;
      4: serase_req = 1;
      5: berase_req = 1;
      default: cycle_done = 1;
    endcase
    #1;
    case (kind)
      2: ok = swr_ok;
      3: ok = prog_ok;
      4: ok = serase_ok;
      5: ok = berase_ok;
      default: ok = 1'b0;
    endcase
    @(negedge clk);
    idle_all();
  endtask

  task automatic write_status(input logic [7:0] d, output logic ok);
    logic dummy;
    strobe(0, 8'h00, 3'd0, dummy);
    strobe(2, d, 3'd0, ok);
    if (ok) strobe(6, 8'h00, 3'd0, dummy);
  endtask

  function automatic logic locked(input int code, input int s);
    int low, span;
    low  = code & 3;
    span = (low == 0) ? 0 : (1 << (low - 1));
    return ((code & 4) != 0) || ((span != 0) && (s >= 8 - span));
  endfunction

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic ok;
    logic [7:0] st;
    idle_all();
    wp_n = 1; busy = 0; swr_data = 0; sector = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    check("R1 status in reset", status_q, 8'h00);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 status after reset", status_q, 8'h00);

    // R7: latch clear, everything refused
    for (int k = 2; k <= 5; k++) begin
      strobe(k, 8'h00, 3'd0, ok);
      check("R7 refused without latch", {7'd0, ok}, 8'h00);
    end

    // R3 latch controls
    strobe(0, 8'h00, 3'd0, ok);
    check("R3 set latch", status_q, 8'h02);
    strobe(1, 8'h00, 3'd0, ok);
    check("R3 clear latch", status_q, 8'h00);
    strobe(0, 8'h00, 3'd0, ok);
    @(negedge clk); wen_set = 1; wen_clr = 1; @(negedge clk); idle_all();
    check("R3 clear wins", status_q, 8'h00);
    @(negedge clk); wen_set = 1; cycle_done = 1; @(negedge clk); idle_all();
    check("R4 done beats set", status_q, 8'h00);

    // R5 sweep of every data byte, pin high
    for (int d = 0; d < 256; d++) begin
      strobe(0, 8'h00, 3'd0, ok);
      strobe(2, 8'(d), 3'd0, ok);
      st = 8'(d) & 8'h9C;
      check("R5 write accepted", {7'd0, ok}, 8'h01);
      check("R5 loaded fields", status_q, st | 8'h02);
      strobe(6, 8'h00, 3'd0, ok);
      check("R4 done clears latch", status_q, st);
    end
    write_status(8'h00, ok);

    // R8 / R9 sweep of area codes and sectors
    for (int code = 0; code < 8; code++) begin
      write_status(8'(code << 2), ok);
      strobe(0, 8'h00, 3'd0, ok);
      for (int s = 0; s < 8; s++) begin
        strobe(3, 8'h00, 3'(s), ok);
        check("R8 program ruling", {7'd0, ok}, {7'd0, !locked(code, s)});
        strobe(4, 8'h00, 3'(s), ok);
        check("R8 sector erase ruling", {7'd0, ok}, {7'd0, !locked(code, s)});
      end
      strobe(5, 8'h00, 3'd0, ok);
      check("R9 full erase ruling", {7'd0, ok}, {7'd0, code == 0});
      check("R11 latch kept after rulings", status_q, 8'(code << 2) | 8'h02);
      strobe(6, 8'h00, 3'd0, ok);
    end
    write_status(8'h00, ok);

    // R6: lock then pin low
    write_status(8'h80, ok);
    @(negedge clk); wp_n = 0; #1;
    check("R6 hw_locked lock then pin", {7'd0, hw_locked}, 8'h01);
    strobe(0, 8'h00, 3'd0, ok);
    strobe(2, 8'h00, 3'd0, ok);
    check("R6 write refused", {7'd0, ok}, 8'h00);
    check("R11 refused keeps byte", status_q, 8'h82);
    strobe(1, 8'h00, 3'd0, ok);
    @(negedge clk); wp_n = 1;
    write_status(8'h00, ok);
    check("R6 pin high unlocks", status_q, 8'h00);
    // R6: pin low then lock
    @(negedge clk); wp_n = 0; #1;
    check("R6 no lock no hw_locked", {7'd0, hw_locked}, 8'h00);
    write_status(8'h84, ok);
    check("R6 lock written with pin low", status_q, 8'h84);
    strobe(0, 8'h00, 3'd0, ok);
    strobe(2, 8'h00, 3'd0, ok);
    check("R6 pin then lock refused", {7'd0, ok}, 8'h00);
    strobe(1, 8'h00, 3'd0, ok);
    @(negedge clk); wp_n = 1;
    write_status(8'h00, ok);

    // R10 / R2: busy blocks everything, wip is live
    strobe(0, 8'h00, 3'd0, ok);
    @(negedge clk); busy = 1; #1;
    check("R2 wip live", status_q, 8'h03);
    for (int k = 2; k <= 5; k++) begin
      strobe(k, 8'h00, 3'd0, ok);
      check("R10 refused while busy", {7'd0, ok}, 8'h00);
    end
    strobe(1, 8'h00, 3'd0, ok);
    check("R3 clear ignored while busy", status_q, 8'h03);
    @(negedge clk); busy = 0; #1;
    check("R2 wip drops", status_q, 8'h02);
    strobe(1, 8'h00, 3'd0, ok);
    check("R3 clear after busy", status_q, 8'h00);

    finish_run();
  end

endmodule